// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block moves one byte at a time over a synchronous three-wire link made of a serial clock, a data input and a data output. One byte register serves for both directions. The host loads it before a transfer. Its most significant bit drives the data output, and the bits arriving on the data input fill the register from the least significant end. The unit can run as a slave, where an external clock drives it. It can also run as a master, where each host strobe inverts the clock line the unit drives out, so one bit takes two strobes.

A configuration input selects which clock edge samples the data input; the opposite edge shifts the register. A 4-bit counter advances on every clock edge, rising or falling. When it passes from 15 to 0, which is 16 edges after a clear, it sets a sticky completion flag and the interrupt request. The host clears the flag by pulsing a clear input. Both serial inputs pass through two-stage synchronisers into the system clock domain. Edges are found on the synchronised clock, or on the internal clock line when the unit is master.

Top module: `tws_shift_unit`

## Requirements
- R1: After reset, data_q is 0x00, cnt_q is 0, ovf_flag and irq are 0, ser_dout is 0 and ser_clk_out is 0.
- R2: With edge_mode = 0, a rising clock edge captures ser_din into a hidden one-bit latch. A falling edge shifts data_q left by one and puts the latch into bit 0. ser_dout always equals data_q[7], so the byte leaves MSB first.
- R3: With edge_mode = 1, the roles of the edges are swapped: a falling edge captures ser_din and a rising edge shifts.
- R4: cnt_q increments by one on every clock edge of either polarity. On the edge that takes it from 15 to 0, ovf_flag is set, and irq always equals ovf_flag.
- R5: Once set, ovf_flag stays set until a cycle with ovf_clr = 1. Clock edges and register writes leave it set.
- R6: If ovf_clr and the overflowing edge fall in the same cycle, the overflow wins and ovf_flag stays 1.
- R7: While cnt_q is nonzero, wr_data_en and wr_cnt_en are ignored. When cnt_q is 0 they load data_q and cnt_q, and such a write takes precedence over an edge in the same cycle.
- R8: With master = 1, each clk_toggle pulse inverts ser_clk_out, and that change counts as one clock edge. In this mode ser_clk_in has no effect.
- R9: Loading cnt_q with a value k while idle makes the overflow occur after 16 - k further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: clock from clk_toggle; 0: clock from ser_clk_in |
| edge_mode | input | 1 | 0: sample on rise, shift on fall; 1: swapped |
| ser_clk_in | input | 1 | External serial clock (slave) |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output, data_q MSB |
| ser_clk_out | output | 1 | Clock line driven in master operation |
| clk_toggle | input | 1 | Host strobe that inverts the master clock line |
| wr_data_en | input | 1 | Load data_q from wr_data |
| wr_data | input | 8 | Data to load |
| wr_cnt_en | input | 1 | Load cnt_q from wr_cnt |
| wr_cnt | input | 4 | Counter value to load |
| ovf_clr | input | 1 | Clear the completion flag |
| data_q | output | 8 | Shift register contents |
| cnt_q | output | 4 | Edge counter |
| ovf_flag | output | 1 | Sticky transfer-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The host clear and the sixteenth counted edge can land in the same cycle, and only a defined priority decides the flag. The bench provokes this in master operation. It issues the final clk_toggle, then raises ovf_clr in exactly the cycle the resulting edge reaches the counter, and expects the flag to remain set. A second collision is an idle write arriving together with an edge. The bench judges it by the rule that the write wins. Along the way, it checks every counter and data value against a behavioural model after each edge.

// File: rtl/tws_pkg.sv
package tws_pkg;
    typedef enum logic {
        EDGE_SAMPLE_RISE = 1'b0,
        EDGE_SAMPLE_FALL = 1'b1
    } edge_mode_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] pipe_q;
    logic [STAGES-1:0][W-1:0] pipe_d;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tws_edge_src.sv
module tws_edge_src (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic clk_toggle,
    input  logic ext_clk_s,
    output logic rise,
    output logic fall,
    output logic mclk
);
    typedef struct packed {
        logic mclk;
        logic line_prev;
    } src_t;

    src_t src_q, src_d;
    logic line;

    assign line = master ? src_q.mclk : ext_clk_s;

    always_comb begin
        src_d           = src_q;
        src_d.line_prev = line;
        if (master && clk_toggle) src_d.mclk = ~src_q.mclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_d;
    end

    assign rise = line & ~src_q.line_prev;
    assign fall = ~line & src_q.line_prev;
    assign mclk = src_q.mclk;

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (master && clk_toggle) |=> (mclk != $past(mclk))); // R8
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!master || !clk_toggle) |=> $stable(mclk)); // R8
endmodule

// File: rtl/tws_core.sv
module tws_core
    import tws_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  edge_mode_e    edge_mode,
    input  logic          rise,
    input  logic          fall,
    input  logic          din_s,
    input  logic          wr_data_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_cnt_en,
    input  logic [CW-1:0] wr_cnt,
    input  logic          ovf_clr,
    output logic [DW-1:0] data_o,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o
);
    localparam logic [CW-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [CW-1:0] cnt;
        logic          latch;
        logic          ovf;
    } core_t;

    core_t st_q, st_d;
    logic  idle, smp, shf, any_edge, wrap;

    always_comb begin
        idle     = (st_q.cnt == '0);
        any_edge = rise | fall;
        smp      = (edge_mode == EDGE_SAMPLE_FALL) ? fall : rise;
        shf      = (edge_mode == EDGE_SAMPLE_FALL) ? rise : fall;
        wrap     = any_edge && (st_q.cnt == CNT_LAST);

        st_d = st_q;
        if (smp)      st_d.latch = din_s;
        if (shf)      st_d.data  = {st_q.data[DW-2:0], st_q.latch};
        if (any_edge) st_d.cnt   = st_q.cnt + 1'b1;
        if (idle && wr_data_en) st_d.data = wr_data;
        if (idle && wr_cnt_en)  st_d.cnt  = wr_cnt;
        if (ovf_clr)  st_d.ovf = 1'b0;
        if (wrap)     st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign cnt_o  = st_q.cnt;
    assign ovf_o  = st_q.ovf;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise || fall) && !(cnt_o == '0 && wr_cnt_en)) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R4
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise || fall) && cnt_o == CNT_LAST) |=> ovf_o); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr) |=> ovf_o); // R5
    AST_BUSY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != '0 && !shf) |=> $stable(data_o)); // R7
    AST_BUSY_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != '0 && !rise && !fall) |=> $stable(cnt_o)); // R7
endmodule

// File: rtl/tws_shift_unit.sv
module tws_shift_unit
    import tws_pkg::*;
#(
    parameter int DW        = 8,
    parameter int CW        = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic          edge_mode,
    input  logic          ser_clk_in,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          ser_clk_out,
    input  logic          clk_toggle,
    input  logic          wr_data_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_cnt_en,
    input  logic [CW-1:0] wr_cnt,
    input  logic          ovf_clr,
    output logic [DW-1:0] data_q,
    output logic [CW-1:0] cnt_q,
    output logic          ovf_flag,
    output logic          irq
);
    logic [1:0] pins_s;
    logic       rise, fall;
    edge_mode_e mode;

    assign mode = edge_mode_e'(edge_mode);

    tws_sync #(.STAGES(SYNC_DEPTH), .W(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_din, ser_clk_in}),
        .sync_o  (pins_s)
    );

    tws_edge_src i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .master     (master),
        .clk_toggle (clk_toggle),
        .ext_clk_s  (pins_s[0]),
        .rise       (rise),
        .fall       (fall),
        .mclk       (ser_clk_out)
    );

    tws_core #(.DW(DW), .CW(CW)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_mode  (mode),
        .rise       (rise),
        .fall       (fall),
        .din_s      (pins_s[1]),
        .wr_data_en (wr_data_en),
        .wr_data    (wr_data),
        .wr_cnt_en  (wr_cnt_en),
        .wr_cnt     (wr_cnt),
        .ovf_clr    (ovf_clr),
        .data_o     (data_q),
        .cnt_o      (cnt_q),
        .ovf_o      (ovf_flag)
    );

    assign ser_dout = data_q[DW-1];
    assign irq      = ovf_flag;
endmodule

// File: tb/test_tws_shift_unit.sv
module test_tws_shift_unit;
    logic clk = 0, rst_n = 0;
    logic master = 0, edge_mode = 0, ser_clk_in = 0, ser_din = 0;
    logic clk_toggle = 0, wr_data_en = 0, wr_cnt_en = 0, ovf_clr = 0;
    logic [7:0] wr_data = 0;
    logic [3:0] wr_cnt = 0;
    logic ser_dout, ser_clk_out, ovf_flag, irq;
    logic [7:0] data_q;
    logic [3:0] cnt_q;

    int total = 0, bad = 0;
    bit done = 0;
    // behavioural model state
    int m_data = 0, m_cnt = 0, m_latch = 0, m_ovf = 0, m_line = 0;

    always #10 clk = ~clk;

    tws_shift_unit i_tws_shift_unit (.*);

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp_all(string tag);
        chk({tag, " data"}, data_q, m_data);
        chk({tag, " cnt"}, cnt_q, m_cnt);
        chk({tag, " ovf"}, ovf_flag, m_ovf);
        chk({tag, " dout"}, ser_dout, (m_data >> 7) & 1);
    endtask

    // per-clock relation between ports: R4 irq follows flag
    always @(negedge clk) if (rst_n && !done) chk("R4 irq", irq, ovf_flag);

    function automatic void model_edge(int lvl);
        int smp = edge_mode ? !lvl : lvl;
        if (smp) m_latch = ser_din;
        else     m_data = ((m_data << 1) | m_latch) & 8'hFF;
        m_cnt = (m_cnt + 1) % 16;
        if (m_cnt == 0) m_ovf = 1;
    endfunction

    task automatic slave_edge();
        ser_clk_in = ~ser_clk_in;
        model_edge(ser_clk_in);
        tick(5);
        cmp_all("R2/R3/R4 slave");
    endtask

    task automatic mstr_edge();
        clk_toggle = 1; tick; clk_toggle = 0;
        m_line = !m_line;
        model_edge(m_line);
        tick(3);
        chk("R8 clk_out", ser_clk_out, m_line);
        cmp_all("R8 master");
    endtask

    task automatic write_data(logic [7:0] v);
        wr_data = v; wr_data_en = 1; tick; wr_data_en = 0;
        if (m_cnt == 0) m_data = v;
        tick;
    endtask

    task automatic write_cnt(logic [3:0] v);
        wr_cnt = v; wr_cnt_en = 1; tick; wr_cnt_en = 0;
        if (m_cnt == 0) m_cnt = v;
        tick;
    endtask

    task automatic clear_flag();
        ovf_clr = 1; tick; ovf_clr = 0; m_ovf = 0; tick;
    endtask

    // 16 slave edges, receiving rx MSB first
    task automatic slave_byte(logic [7:0] rx);
        int b = 7;
        for (int e = 0; e < 16; e++) begin
            int nxt = !ser_clk_in;
            if ((edge_mode ? !nxt : nxt) && b >= 0) begin
                ser_din = rx[b]; b--; tick(3);
            end
            slave_edge();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 data", data_q, 0); chk("R1 cnt", cnt_q, 0);
        chk("R1 ovf", ovf_flag, 0); chk("R1 irq", irq, 0);
        chk("R1 dout", ser_dout, 0); chk("R1 clkout", ser_clk_out, 0);
        rst_n = 1; tick(2);

        // R2 mode 0 byte: load A5, receive 3C
        write_data(8'hA5); write_cnt(0);
        chk("R2 dout msb", ser_dout, 1);
        slave_byte(8'h3C);
        chk("R2 rx byte", data_q, 8'h3C);
        chk("R4 ovf after 16", ovf_flag, 1);
        chk("R4 cnt wrapped", cnt_q, 0);

        // R5 flag sticky through writes and edges
        write_data(8'hF0);
        chk("R5 sticky", ovf_flag, 1);
        slave_edge();
        chk("R5 sticky edge", ovf_flag, 1);
        // R7 busy writes ignored (cnt now 1)
        write_data(8'h11); write_cnt(4'h9);
        cmp_all("R7 ignored");
        for (int e = 0; e < 15; e++) slave_edge();
        clear_flag();
        chk("R5 cleared", ovf_flag, 0);

        // R3 mode 1 byte, MSB-first from 96, receive C3
        edge_mode = 1; tick(2);
        write_data(8'h96); write_cnt(0);
        slave_byte(8'hC3);
        chk("R3 ovf", ovf_flag, 1);
        clear_flag();

        // R9 preset count: overflow after 16-12 edges
        edge_mode = 0; tick(2);
        write_cnt(4'd12);
        for (int e = 0; e < 3; e++) slave_edge();
        chk("R9 not yet", ovf_flag, 0);
        slave_edge();
        chk("R9 ovf at 4th", ovf_flag, 1);
        clear_flag();

        // R8 master mode, external clock ignored
        master = 1; tick(3);
        ser_clk_in = 1; tick(6);
        cmp_all("R8 ext ignored");
        ser_clk_in = 0; tick(6);
        write_data(8'h5A); ser_din = 1; tick(3);
        for (int e = 0; e < 15; e++) mstr_edge();
        // R6 clear collides with overflowing edge
        clk_toggle = 1; tick; clk_toggle = 0; ovf_clr = 1; tick; ovf_clr = 0;
        m_line = !m_line; model_edge(m_line);
        tick(2);
        chk("R6 set wins", ovf_flag, 1);
        cmp_all("R6 state");
        clear_flag();

        // R7 idle write wins over simultaneous edge
        wr_data = 8'h77; wr_data_en = 1; clk_toggle = 1; tick;
        clk_toggle = 0; wr_cnt = 4'd0; wr_cnt_en = 1; tick;
        wr_data_en = 0; wr_cnt_en = 0;
        m_line = !m_line; m_data = 8'h77; m_cnt = 0; tick(2);
        chk("R7 write wins data", data_q, 8'h77);
        chk("R7 write wins cnt", cnt_q, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule